// File: doc/BRIEF.md
# Compact-ISA Integer ALU and Condition-Bit Unit

This block is the combinational execute stage for the integer subset of a 16-bit fixed-length RISC instruction set. The machine has sixteen 32-bit general registers and one condition bit, T. Each cycle the unit takes one instruction word, the values of the two named operand registers (destination/first source `Rn` and second source `Rm`), the value of R0, the current T bit and the two divide-step bits M and Q.

From these it produces four things:
- a 32-bit result;
- a register write strobe, with a select that names R0 or `Rn` as the destination;
- the next T, M and Q bits;
- a flag that marks an instruction word the unit does not recognise.

Decode happens inside the unit. A control part maps the fixed opcode patterns to a small strobe record, and a datapath part computes the values. The surrounding pipeline uses the write strobe and destination select to update its register file, and latches T, M and Q from the unit's outputs every cycle.

Top module: `cmpalu_top`

## Requirements
- R1: Add (`0011 nnnn mmmm 1100`) writes Rn+Rm to Rn. Add-immediate (`0111 nnnn iiiiiiii`) writes Rn plus the sign-extended 8-bit immediate to Rn. Neither changes T.
- R2: Add-with-carry (minor `1110` under major `0011`) writes Rn+Rm+T to Rn. T becomes 1 when either partial sum wraps: first Rn+T, then that sum plus Rm.
- R3: Add-with-overflow (minor `1111` under major `0011`) writes Rn+Rm to Rn. T is set exactly when both operands have the same sign and the sum's sign differs from it.
- R4: Register AND (`0010 nnnn mmmm 1001`) writes Rn&Rm to Rn with destination select 0. Immediate AND (`11001001 iiiiiiii`) writes R0 AND the zero-extended immediate with destination select 1. T is unchanged by both.
- R5: Compares under major `0011` write only T and leave the write strobe low. The minors are:
  - `0000`: equal
  - `0011`: signed Rn>=Rm
  - `0111`: signed Rn>Rm
  - `0110`: unsigned Rn>Rm
  - `0010`: unsigned Rn>=Rm
- R6: The byte compare (`0010 nnnn mmmm 1100`) sets T when any byte lane of Rn equals the same lane of Rm. Otherwise it clears T. It makes no register write.
- R7: Decrement-and-test (`0100 nnnn 00010000`) writes Rn-1 to Rn, wrapping from 0 to all ones. T is set only when the new value is zero.
- R8: `0100 nnnn 00010101` sets T when Rn is signed-positive (above zero). `0100 nnnn 00010001` sets T when Rn is signed zero-or-positive. Neither writes a register.
- R9: Under major `0110`, the minor selects an extension of Rm written into Rn:
  - `1110`: sign-extend the low byte
  - `1111`: sign-extend the low halfword
  - `1100`: zero-extend the low byte
  - `1101`: zero-extend the low halfword
- R10: Signed divide-init (`0010 nnnn mmmm 0111`) sets Q to bit 31 of Rn, M to bit 31 of Rm, and T to M XOR Q. It makes no register write.
- R11: Unsigned divide-init (word `0x0019`) clears M, Q and T. Clear-T (word `0x0008`) clears T and leaves M and Q as they came in.
- R12: Any other word raises the illegal flag, keeps the write strobe low, and passes T, M and Q through unchanged.
- R13: Whenever the write strobe is low the result is zero. M and Q pass through for every operation except the two divide-init steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 16 | Instruction word being executed |
| rnVal | input | 32 | Value of the register named in bits 11:8 |
| rmVal | input | 32 | Value of the register named in bits 7:4 |
| r0Val | input | 32 | Value of R0 |
| tIn | input | 1 | Current T bit |
| mIn | input | 1 | Current M bit |
| qIn | input | 1 | Current Q bit |
| result | output | 32 | Value to write back; zero when no write |
| wrEn | output | 1 | Register write strobe |
| wrR0 | output | 1 | Destination select: 1 = R0, 0 = Rn |
| tOut | output | 1 | Next T bit |
| mOut | output | 1 | Next M bit |
| qOut | output | 1 | Next Q bit |
| illegal | output | 1 | Unrecognised instruction word |

## Verification
The functions that overlap in one cycle are the register write and the condition update. Add-with-carry, add-with-overflow and decrement-and-test each produce a result and a new T together. The bench provokes this with operands that wrap on exactly one of the two carry stages, with operand signs that overflow or just miss overflowing, and with decrement from one and from zero. It then compares the whole output tuple at once, so a correct sum with a stale T, or the reverse, is reported. Random words and operands are judged against a bench model of the same tuple.

// File: rtl/cmpalu_pkg.sv
package cmpalu_pkg;

  localparam int INSTR_W = 16;
  localparam int IMM_W   = 8;

  typedef enum logic [4:0] {
    OP_NONE,
    OP_ADD,
    OP_ADDI,
    OP_ADDC,
    OP_ADDV,
    OP_AND,
    OP_ANDI,
    OP_CMPEQ,
    OP_CMPGE,
    OP_CMPGT,
    OP_CMPHI,
    OP_CMPHS,
    OP_CMPSTR,
    OP_DT,
    OP_CMPPL,
    OP_CMPPZ,
    OP_EXTSB,
    OP_EXTSW,
    OP_EXTUB,
    OP_EXTUW,
    OP_DIV0S,
    OP_DIV0U,
    OP_CLRT
  } aluOp_e;

  typedef struct packed {
    aluOp_e op;
    logic   writeReg;
    logic   writeR0;
    logic   writeT;
    logic   writeMQ;
    logic   illegal;
  } aluStrobe_t;

endpackage

// File: rtl/cmpalu_decode.sv
module cmpalu_decode
  import cmpalu_pkg::*;
(
  input  logic [INSTR_W-1:0] instrWord,
  output aluStrobe_t         strobe,
  output logic [IMM_W-1:0]   immVal
);

  logic [3:0] major;
  logic [3:0] minor;
  logic [7:0] lowByte;
  aluOp_e     opSel;

  assign major   = instrWord[15:12];
  assign minor   = instrWord[3:0];
  assign lowByte = instrWord[7:0];
  assign immVal  = instrWord[IMM_W-1:0];

  always_comb begin
    opSel = OP_NONE;
    unique case (major)
      4'h3: begin
        case (minor)
          4'b1100: opSel = OP_ADD;
          4'b1110: opSel = OP_ADDC;
          4'b1111: opSel = OP_ADDV;
          4'b0000: opSel = OP_CMPEQ;
          4'b0011: opSel = OP_CMPGE;
          4'b0111: opSel = OP_CMPGT;
          4'b0110: opSel = OP_CMPHI;
          4'b0010: opSel = OP_CMPHS;
          default: opSel = OP_NONE;
        endcase
      end
      4'h7: opSel = OP_ADDI;
      4'hC: if (instrWord[11:8] == 4'b1001) opSel = OP_ANDI;
      4'h2: begin
        case (minor)
          4'b1001: opSel = OP_AND;
          4'b1100: opSel = OP_CMPSTR;
          4'b0111: opSel = OP_DIV0S;
          default: opSel = OP_NONE;
        endcase
      end
      4'h4: begin
        case (lowByte)
          8'h10:   opSel = OP_DT;
          8'h15:   opSel = OP_CMPPL;
          8'h11:   opSel = OP_CMPPZ;
          default: opSel = OP_NONE;
        endcase
      end
      4'h6: begin
        case (minor)
          4'b1110: opSel = OP_EXTSB;
          4'b1111: opSel = OP_EXTSW;
          4'b1100: opSel = OP_EXTUB;
          4'b1101: opSel = OP_EXTUW;
          default: opSel = OP_NONE;
        endcase
      end
      4'h0: begin
        if (instrWord == 16'h0008)      opSel = OP_CLRT;
        else if (instrWord == 16'h0019) opSel = OP_DIV0U;
      end
      default: opSel = OP_NONE;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.op       = opSel;
    strobe.illegal  = (opSel == OP_NONE);
    case (opSel)
      OP_ADD, OP_ADDI, OP_AND,
      OP_EXTSB, OP_EXTSW, OP_EXTUB, OP_EXTUW: strobe.writeReg = 1'b1;
      OP_ADDC, OP_ADDV, OP_DT: begin
        strobe.writeReg = 1'b1;
        strobe.writeT   = 1'b1;
      end
      OP_ANDI: begin
        strobe.writeReg = 1'b1;
        strobe.writeR0  = 1'b1;
      end
      OP_CMPEQ, OP_CMPGE, OP_CMPGT, OP_CMPHI, OP_CMPHS,
      OP_CMPSTR, OP_CMPPL, OP_CMPPZ, OP_CLRT: strobe.writeT = 1'b1;
      OP_DIV0S, OP_DIV0U: begin
        strobe.writeT  = 1'b1;
        strobe.writeMQ = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cmpalu_datapath.sv
module cmpalu_datapath
  import cmpalu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  aluStrobe_t        strobe,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [DATA_W-1:0] r0Val,
  input  logic              tIn,
  input  logic              mIn,
  input  logic              qIn,
  output logic [DATA_W-1:0] result,
  output logic              tOut,
  output logic              mOut,
  output logic              qOut
);

  localparam int LANES = DATA_W / 8;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W:0]   sumPlain;
  logic [DATA_W:0]   sumImm;
  logic [DATA_W:0]   carryStepA;
  logic [DATA_W:0]   carryStepB;
  logic [DATA_W-1:0] immSext;
  logic [DATA_W-1:0] decVal;
  logic [DATA_W-1:0] laneXor;
  logic [LANES-1:0]  laneHit;
  logic              ovfFlag;
  logic [DATA_W-1:0] rawRes;
  logic              newT;
  logic              newM;
  logic              newQ;

  assign laneXor = rnVal ^ rmVal;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign laneHit[g] = (laneXor[8*g +: 8] == 8'h00);
    end
  endgenerate

  always_comb begin
    immSext    = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
    sumPlain   = {1'b0, rnVal} + {1'b0, rmVal};
    sumImm     = {1'b0, rnVal} + {1'b0, immSext};
    carryStepA = {1'b0, rnVal} + {{DATA_W{1'b0}}, tIn};
    carryStepB = {1'b0, carryStepA[MSB:0]} + {1'b0, rmVal};
    ovfFlag    = ~(rnVal[MSB] ^ rmVal[MSB]) & (sumPlain[MSB] ^ rnVal[MSB]);
    decVal     = rnVal - {{(DATA_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    rawRes = '0;
    newT   = tIn;
    newM   = mIn;
    newQ   = qIn;
    case (strobe.op)
      OP_ADD:    rawRes = sumPlain[MSB:0];
      OP_ADDI:   rawRes = sumImm[MSB:0];
      OP_ADDC: begin
        rawRes = carryStepB[MSB:0];
        newT   = carryStepA[DATA_W] | carryStepB[DATA_W];
      end
      OP_ADDV: begin
        rawRes = sumPlain[MSB:0];
        newT   = ovfFlag;
      end
      OP_AND:    rawRes = rnVal & rmVal;
      OP_ANDI:   rawRes = r0Val & {{(DATA_W-IMM_W){1'b0}}, immVal};
      OP_CMPEQ:  newT = (rnVal == rmVal);
      OP_CMPGE:  newT = ($signed(rnVal) >= $signed(rmVal));
      OP_CMPGT:  newT = ($signed(rnVal) > $signed(rmVal));
      OP_CMPHI:  newT = (rnVal > rmVal);
      OP_CMPHS:  newT = (rnVal >= rmVal);
      OP_CMPSTR: newT = |laneHit;
      OP_DT: begin
        rawRes = decVal;
        newT   = (decVal == '0);
      end
      OP_CMPPL:  newT = ~rnVal[MSB] & (|rnVal);
      OP_CMPPZ:  newT = ~rnVal[MSB];
      OP_EXTSB:  rawRes = {{(DATA_W-8){rmVal[7]}}, rmVal[7:0]};
      OP_EXTSW:  rawRes = {{(DATA_W-16){rmVal[15]}}, rmVal[15:0]};
      OP_EXTUB:  rawRes = {{(DATA_W-8){1'b0}}, rmVal[7:0]};
      OP_EXTUW:  rawRes = {{(DATA_W-16){1'b0}}, rmVal[15:0]};
      OP_DIV0S: begin
        newQ = rnVal[MSB];
        newM = rmVal[MSB];
        newT = rnVal[MSB] ^ rmVal[MSB];
      end
      OP_DIV0U: begin
        newQ = 1'b0;
        newM = 1'b0;
        newT = 1'b0;
      end
      OP_CLRT:   newT = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    result = strobe.writeReg ? rawRes : '0;
    tOut   = strobe.writeT   ? newT   : tIn;
    mOut   = strobe.writeMQ  ? newM   : mIn;
    qOut   = strobe.writeMQ  ? newQ   : qIn;
  end

  always_comb begin
    if (strobe.op == OP_DIV0S) begin
      AST_DIV_INIT_T: assert (tOut == (mOut != qOut)) else $error("T disagrees with M and Q"); // R10
    end
    if (strobe.op == OP_DT) begin
      AST_DEC_ZERO: assert (tOut == (rnVal == {{(DATA_W-1){1'b0}}, 1'b1})) else $error("decrement T wrong"); // R7
    end
    if (strobe.op == OP_ADDV && tOut) begin
      AST_OVF_SIGNS: assert ((rnVal[MSB] == rmVal[MSB]) && (result[MSB] != rnVal[MSB])) else $error("overflow flag without sign change"); // R3
    end
  end

endmodule

// File: rtl/cmpalu_top.sv
module cmpalu_top
  import cmpalu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic [15:0]       instrWord,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [DATA_W-1:0] r0Val,
  input  logic              tIn,
  input  logic              mIn,
  input  logic              qIn,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              wrR0,
  output logic              tOut,
  output logic              mOut,
  output logic              qOut,
  output logic              illegal
);

  aluStrobe_t       strobe;
  logic [IMM_W-1:0] immVal;

  cmpalu_decode u_decode (
    .instrWord (instrWord),
    .strobe    (strobe),
    .immVal    (immVal)
  );

  cmpalu_datapath #(.DATA_W(DATA_W)) u_datapath (
    .strobe (strobe),
    .immVal (immVal),
    .rnVal  (rnVal),
    .rmVal  (rmVal),
    .r0Val  (r0Val),
    .tIn    (tIn),
    .mIn    (mIn),
    .qIn    (qIn),
    .result (result),
    .tOut   (tOut),
    .mOut   (mOut),
    .qOut   (qOut)
  );

  assign wrEn    = strobe.writeReg;
  assign wrR0    = strobe.writeR0;
  assign illegal = strobe.illegal;

  always_comb begin
    if (illegal) begin
      AST_ILLEGAL_INERT: assert (!wrEn && tOut == tIn && mOut == mIn && qOut == qIn) else $error("illegal word changed state"); // R12
    end
    if (!wrEn) begin
      AST_IDLE_RESULT: assert (result == '0) else $error("result nonzero without write"); // R13
    end
  end

endmodule

// File: tb/cmpalu_top_tb_top.sv
module cmpalu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instrWord;
  logic [31:0] rnVal, rmVal, r0Val, result;
  logic        tIn, mIn, qIn, wrEn, wrR0, tOut, mOut, qOut, illegal;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cmpalu_top dut_i (
    .instrWord(instrWord), .rnVal(rnVal), .rmVal(rmVal), .r0Val(r0Val),
    .tIn(tIn), .mIn(mIn), .qIn(qIn), .result(result), .wrEn(wrEn),
    .wrR0(wrR0), .tOut(tOut), .mOut(mOut), .qOut(qOut), .illegal(illegal)
  );

  // {instr, rn, rm, r0, t, m, q, expResult, expWr, expWrR0, expT, expM, expQ, expIll}
  localparam int NV = 29;
  localparam logic [152:0] VEC [NV] = '{
    {16'h312C, 32'd5, 32'd7, 32'd0, 3'b100, 32'd12, 6'b101000},                               // R1 add
    {16'h71FF, 32'h10, 32'd0, 32'd0, 3'b000, 32'h0F, 6'b100000},                              // R1 add imm -1
    {16'h312E, 32'hFFFFFFFF, 32'd0, 32'd0, 3'b100, 32'd0, 6'b101000},                         // R2 carry at first step
    {16'h312E, 32'd1, 32'd2, 32'd0, 3'b100, 32'd4, 6'b100000},                                // R2 no carry
    {16'h312E, 32'h80000000, 32'h80000000, 32'd0, 3'b000, 32'd0, 6'b101000},                  // R2 carry at second step
    {16'h312F, 32'h7FFFFFFF, 32'd1, 32'd0, 3'b000, 32'h80000000, 6'b101000},                  // R3 overflow
    {16'h312F, 32'hFFFFFFFF, 32'd1, 32'd0, 3'b100, 32'd0, 6'b100000},                         // R3 wrap without overflow
    {16'h2129, 32'h0000F0F0, 32'h0000FF00, 32'd0, 3'b100, 32'h0000F000, 6'b101000},           // R4 and reg
    {16'hC9F0, 32'd0, 32'd0, 32'hFFFFFFFF, 3'b000, 32'h000000F0, 6'b110000},                  // R4 and imm to R0
    {16'h3120, 32'd9, 32'd9, 32'd0, 3'b000, 32'd0, 6'b001000},                                // R5 eq
    {16'h3123, 32'hFFFFFFFF, 32'd1, 32'd0, 3'b100, 32'd0, 6'b000000},                         // R5 ge signed
    {16'h3122, 32'hFFFFFFFF, 32'd1, 32'd0, 3'b000, 32'd0, 6'b001000},                         // R5 hs unsigned
    {16'h3127, 32'd5, 32'd5, 32'd0, 3'b100, 32'd0, 6'b000000},                                // R5 gt equal operands
    {16'h3126, 32'd6, 32'd5, 32'd0, 3'b000, 32'd0, 6'b001000},                                // R5 hi
    {16'h212C, 32'h11223344, 32'h55663377, 32'd0, 3'b000, 32'd0, 6'b001000},                  // R6 one lane matches
    {16'h212C, 32'h11223344, 32'h22334455, 32'd0, 3'b100, 32'd0, 6'b000000},                  // R6 no lane matches
    {16'h4110, 32'd1, 32'd0, 32'd0, 3'b000, 32'd0, 6'b101000},                                // R7 reaches zero
    {16'h4110, 32'd0, 32'd0, 32'd0, 3'b100, 32'hFFFFFFFF, 6'b100000},                         // R7 wraps
    {16'h4115, 32'd0, 32'd0, 32'd0, 3'b100, 32'd0, 6'b000000},                                // R8 positive of zero
    {16'h4111, 32'd0, 32'd0, 32'd0, 3'b000, 32'd0, 6'b001000},                                // R8 zero-or-positive
    {16'h612E, 32'd0, 32'h00000080, 32'd0, 3'b000, 32'hFFFFFF80, 6'b100000},                  // R9 sext byte
    {16'h612F, 32'd0, 32'h00017FFF, 32'd0, 3'b000, 32'h00007FFF, 6'b100000},                  // R9 sext half
    {16'h612C, 32'd0, 32'hFFFFFF80, 32'd0, 3'b000, 32'h00000080, 6'b100000},                  // R9 zext byte
    {16'h612D, 32'd0, 32'hFFFF8000, 32'd0, 3'b000, 32'h00008000, 6'b100000},                  // R9 zext half
    {16'h2127, 32'h80000000, 32'd1, 32'd0, 3'b000, 32'd0, 6'b001010},                         // R10 signed init
    {16'h0019, 32'd0, 32'd0, 32'd0, 3'b111, 32'd0, 6'b000000},                                // R11 unsigned init
    {16'h0008, 32'd0, 32'd0, 32'd0, 3'b110, 32'd0, 6'b000100},                                // R11 clear T
    {16'hFFFF, 32'd3, 32'd4, 32'd0, 3'b110, 32'd0, 6'b001101},                                // R12 unknown word
    {16'h4120, 32'd3, 32'd4, 32'd0, 3'b001, 32'd0, 6'b000011}                                 // R12 unknown minor
  };
  localparam int VREQ [NV] = '{1,1,2,2,2,3,3,4,4,5,5,5,5,5,6,6,7,7,8,8,9,9,9,9,10,11,11,12,12};

  function automatic logic [37:0] model(input logic [15:0] w, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] z,
                                        input logic t, input logic m, input logic q);
    logic [31:0] r = 32'd0;
    logic wr = 0, toR0 = 0, ill = 0;
    logic [32:0] wide;
    casez (w)
      16'b0011????????1100: begin wr = 1; r = a + b; end
      16'b0011????????1110: begin wr = 1; wide = 33'(a) + 33'(b) + 33'(t); r = wide[31:0]; t = wide[32]; end
      16'b0011????????1111: begin wr = 1; r = a + b; t = (a[31] == b[31]) && (r[31] != a[31]); end
      16'b0011????????0000: t = (a == b);
      16'b0011????????0011: t = ($signed(a) >= $signed(b));
      16'b0011????????0111: t = ($signed(a) > $signed(b));
      16'b0011????????0110: t = (a > b);
      16'b0011????????0010: t = (a >= b);
      16'b0111????????????: begin wr = 1; r = a + {{24{w[7]}}, w[7:0]}; end
      16'b11001001????????: begin wr = 1; toR0 = 1; r = z & {24'd0, w[7:0]}; end
      16'b0010????????1001: begin wr = 1; r = a & b; end
      16'b0010????????1100: t = (a[31:24] == b[31:24]) || (a[23:16] == b[23:16]) ||
                                (a[15:8] == b[15:8]) || (a[7:0] == b[7:0]);
      16'b0010????????0111: begin q = a[31]; m = b[31]; t = q ^ m; end
      16'b0100????00010000: begin wr = 1; r = a - 1; t = (a == 32'd1); end
      16'b0100????00010101: t = ($signed(a) > 0);
      16'b0100????00010001: t = ($signed(a) >= 0);
      16'b0110????????1110: begin wr = 1; r = {{24{b[7]}}, b[7:0]}; end
      16'b0110????????1111: begin wr = 1; r = {{16{b[15]}}, b[15:0]}; end
      16'b0110????????1100: begin wr = 1; r = {24'd0, b[7:0]}; end
      16'b0110????????1101: begin wr = 1; r = {16'd0, b[15:0]}; end
      16'h0008: t = 0;
      16'h0019: begin t = 0; m = 0; q = 0; end
      default: ill = 1;
    endcase
    return {r, wr, toR0, t, m, q, ill};
  endfunction

  task automatic judge(input string tag, input logic [37:0] exp);
    logic [37:0] got = {result, wrEn, wrR0, tOut, mOut, qOut, illegal};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] z, input logic [2:0] tmq);
    @(posedge clk);
    instrWord = w; rnVal = a; rmVal = b; r0Val = z;
    {tIn, mIn, qIn} = tmq;
    @(negedge clk);
  endtask

  function automatic logic [31:0] corner(input int unsigned k);
    case (k % 8)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFFFFFF;
      3: return 32'h7FFFFFFF;
      4: return 32'h80000000;
      default: return $urandom;
    endcase
  endfunction

  localparam logic [15:0] BASES [22] = '{
    16'h300C, 16'h300E, 16'h300F, 16'h3000, 16'h3003, 16'h3007, 16'h3006, 16'h3002,
    16'h7000, 16'hC900, 16'h2009, 16'h200C, 16'h2007, 16'h4010, 16'h4015, 16'h4011,
    16'h600E, 16'h600F, 16'h600C, 16'h600D, 16'h0008, 16'h0019
  };

  initial begin
    instrWord = 16'h0000; rnVal = '0; rmVal = '0; r0Val = '0;
    tIn = 0; mIn = 0; qIn = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    judge("R12 idle word after reset", {32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][152:137], VEC[i][136:105], VEC[i][104:73], VEC[i][72:41], VEC[i][40:38]);
      judge($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][37:0]);
    end

    for (int i = 0; i < 1500; i++) begin
      logic [15:0] w;
      logic [31:0] a, b, z;
      logic [2:0]  tmq;
      int unsigned pick = $urandom_range(0, 25);
      if (pick < 22) begin
        w = BASES[pick];
        if (w[15:12] != 4'h0) w[11:8] = 4'($urandom);
        if (w[15:12] == 4'h7 || w[15:12] == 4'hC) w[7:0] = 8'($urandom);
        else if (w[15:12] != 4'h0 && w[15:12] != 4'h4) w[7:4] = 4'($urandom);
      end else begin
        w = 16'($urandom);
      end
      a = corner($urandom);
      b = (i % 5 == 0) ? {a[31:8], 8'($urandom)} : corner($urandom);
      z = $urandom;
      tmq = 3'($urandom);
      apply(w, a, b, z, tmq);
      judge($sformatf("R13 random word %h", w), model(w, a, b, z, tmq[2], tmq[1], tmq[0]));
    end

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule